// File: doc/BRIEF.md
# Programmable-Level Interrupt Request Unit

This unit turns two kinds of interrupt sources into prioritised request levels. One source is a shared external pin, active low, whose meaning is set by a 3-bit level field: any non-zero level makes it a level-sensitive interrupt request at that priority. Zero turns it into a bus-error input instead. The other source is a group of edge-detect input lines. A rising edge on an enabled line sets a sticky pending flag, and the group as a whole requests at its own programmable level.

Software sees two 16-bit registers. Address 0 holds a level byte in bits [15:8] and an 8-bit vector number in bits [7:0]. Address 1 holds the per-line enable mask in bits [15:8] and the pending flags in bits [7:0]. When the interrupt acknowledge strobe is raised, the unit compares the acknowledged level with its own requests. It answers either with the vector number for the edge group or with an autovector indication for the pin. At a shared level the pin always wins over the edge group.

Top module: `irq_level_unit`

## Requirements
- R1: After reset the pin level field is 1, the edge level field is 0, the enable mask and pending flags are 0, and address 0 reads 0x100F. With the pin held low, the unit then requests at level 1.
- R2: The pin input passes through two synchronizing flops. While the pin level field (address 0 bits [14:12]) is non-zero and the synchronized pin is low, pin_req_lvl equals that field and berr_out is 0. Otherwise pin_req_lvl is 0.
- R3: While the pin level field is zero, berr_out is 1 exactly when the synchronized pin is low, and pin_req_lvl is 0.
- R4: Bits 15 and 11 of address 0 (bits 7 and 3 of the level byte) always read 0, and writing 1 to them has no effect on any other field.
- R5: A rising edge on edge_in[i] sets pending bit i three clock edges later, but only if enable bit i (address 1 bit 8+i) is set. Falling edges and edges on disabled lines leave the pending flags unchanged.
- R6: Writing address 1 with bit i of the low byte at 1 clears pending bit i, and a 0 leaves it alone. If the write and a new edge set land in the same cycle, the set wins.
- R7: edge_req_lvl equals the edge level field (address 0 bits [10:8]) while any pending flag is set and that field is non-zero. Otherwise it is 0.
- R8: With iack high and a non-zero iack_lvl equal to edge_req_lvl, and the pin not requesting at that level, ack_vec_valid is 1 and ack_vec equals address 0 bits [7:0].
- R9: With iack high and a non-zero iack_lvl equal to pin_req_lvl, ack_auto is 1 and ack_vec_valid is 0, even when the edge group requests at the same level.
- R10: The vector byte resets to 0x0F and takes whatever is written to address 0 bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 config, 1 enable/pending |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| pin_n | input | 1 | Shared external request / bus-error pin, active low |
| edge_in | input | NUM_EDGE | Edge-detect lines |
| berr_out | output | 1 | Bus-error indication from the shared pin |
| pin_req_lvl | output | 3 | Request level of the pin source |
| edge_req_lvl | output | 3 | Request level of the edge group |
| iack | input | 1 | Interrupt acknowledge strobe |
| iack_lvl | input | 3 | Level being acknowledged |
| ack_vec_valid | output | 1 | Edge group answers with its vector |
| ack_vec | output | 8 | Vector number returned |
| ack_auto | output | 1 | Pin source answers with autovector |

## Verification
Two functions can land in the same cycle. A software clear of a pending flag can coincide with the internal set from a new edge on that line. The bench holds the flag pending, raises the line's input, and times the clearing write so that it registers on the same clock edge as the set. It then expects the flag to read 1, and a later write on its own must bring it to 0. A second overlap is the pin and the edge group requesting at one level. An acknowledge at that level must give the autovector and no vector.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    lvl_t       pin_lvl;
    lvl_t       edge_lvl;
    logic [7:0] vec;
  } cfg_t;

  // level byte layout: {0, pin[2:0], 0, edge[2:0]}
  function automatic logic [7:0] pack_lvl_byte(lvl_t p, lvl_t e);
    return {1'b0, p, 1'b0, e};
  endfunction

  function automatic lvl_t gate_lvl(lvl_t l, logic active);
    return active ? l : '0;
  endfunction

  function automatic logic lvl_hit(lvl_t req, lvl_t ack);
    return (ack != '0) && (req == ack);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_lvl_pkg::*;
#(
  parameter int         NUM_EDGE     = 4,
  parameter lvl_t       RST_PIN_LVL  = 3'd1,
  parameter lvl_t       RST_EDGE_LVL = 3'd0,
  parameter logic [7:0] RST_VEC      = 8'h0F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                addr,
  input  logic [15:0]         wdata,
  input  logic [NUM_EDGE-1:0] pend,
  output cfg_t                cfg,
  output logic [NUM_EDGE-1:0] en,
  output logic [NUM_EDGE-1:0] clr,
  output logic [15:0]         rdata
);
  localparam int PAD = 8 - NUM_EDGE;

  logic wr_cfg, wr_pend;
  logic [7:0] en8, pend8;

  assign wr_cfg  = wr && !addr;
  assign wr_pend = wr && addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.pin_lvl  <= RST_PIN_LVL;
      cfg.edge_lvl <= RST_EDGE_LVL;
      cfg.vec      <= RST_VEC;
    end else if (wr_cfg) begin
      cfg.pin_lvl  <= wdata[14:12];
      cfg.edge_lvl <= wdata[10:8];
      cfg.vec      <= wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else if (wr_pend) en <= wdata[8 +: NUM_EDGE];
  end

  assign clr = wr_pend ? wdata[NUM_EDGE-1:0] : '0;

  generate
    if (PAD > 0) begin : g_pad
      assign en8   = {{PAD{1'b0}}, en};
      assign pend8 = {{PAD{1'b0}}, pend};
    end else begin : g_full
      assign en8   = en;
      assign pend8 = pend;
    end
  endgenerate

  always_comb begin
    if (!addr) rdata = {pack_lvl_byte(cfg.pin_lvl, cfg.edge_lvl), cfg.vec};
    else       rdata = {en8, pend8};
  end

  // R4: reserved positions never read back as 1
  assert_rsv_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !addr |-> (rdata[15] == 1'b0 && rdata[11] == 1'b0));
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int NUM_EDGE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EDGE-1:0] edge_in,
  input  logic [NUM_EDGE-1:0] en,
  input  logic [NUM_EDGE-1:0] clr,
  output logic [NUM_EDGE-1:0] pend
);
  logic [NUM_EDGE-1:0] sync_q, prev_q, rise, set;

  irq_sync #(.W(NUM_EDGE), .RST_VAL('0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(edge_in), .q(sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q;
  end

  assign rise = sync_q & ~prev_q;
  assign set  = rise & en;

  generate
    for (genvar i = 0; i < NUM_EDGE; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend[i] <= 1'b0;
        else if (set[i]) pend[i] <= 1'b1;   // set beats clear
        else if (clr[i]) pend[i] <= 1'b0;
      end
    end
  endgenerate

  // R5: a qualified edge always leaves its flag set
  assert_set_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((pend & $past(set)) == $past(set)));
  // R6: a clear without a competing set empties the flag
  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((pend & $past(clr & ~set)) == '0));
  // R5: a flag never rises without a qualified edge
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend & ~set) != '0) |=> ((pend & $past(~pend & ~set)) == '0));
endmodule

// File: rtl/irq_ack_sel.sv
module irq_ack_sel
  import irq_lvl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iack,
  input  lvl_t       iack_lvl,
  input  lvl_t       pin_req,
  input  lvl_t       edge_req,
  input  logic [7:0] vec,
  output logic       ack_vec_valid,
  output logic [7:0] ack_vec,
  output logic       ack_auto
);
  logic pin_hit, edge_hit;

  assign pin_hit  = iack && lvl_hit(pin_req, iack_lvl);
  assign edge_hit = iack && lvl_hit(edge_req, iack_lvl);

  // edge group loses any tie with the pin
  assign ack_auto      = pin_hit;
  assign ack_vec_valid = edge_hit && !pin_hit;
  assign ack_vec       = ack_vec_valid ? vec : 8'h00;

  // R9: never both answers at once
  assert_ack_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_vec_valid && ack_auto));
  // R8: vector answer only for the edge group's active level
  assert_vec_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vec_valid |-> (edge_req == iack_lvl && edge_req != '0));
endmodule

// File: rtl/irq_level_unit.sv
module irq_level_unit
  import irq_lvl_pkg::*;
#(
  parameter int NUM_EDGE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_addr,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata,
  input  logic                pin_n,
  input  logic [NUM_EDGE-1:0] edge_in,
  output logic                berr_out,
  output logic [2:0]          pin_req_lvl,
  output logic [2:0]          edge_req_lvl,
  input  logic                iack,
  input  logic [2:0]          iack_lvl,
  output logic                ack_vec_valid,
  output logic [7:0]          ack_vec,
  output logic                ack_auto
);
  cfg_t                cfg;
  logic [NUM_EDGE-1:0] en, clr, pend;
  logic                pin_sync_n, pin_low, pin_is_berr, any_pend;

  irq_cfg_regs #(.NUM_EDGE(NUM_EDGE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .pend(pend), .cfg(cfg), .en(en), .clr(clr),
    .rdata(bus_rdata)
  );

  irq_sync #(.W(1), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_sync_n)
  );

  irq_edge_pend #(.NUM_EDGE(NUM_EDGE)) u_edge (
    .clk(clk), .rst_n(rst_n), .edge_in(edge_in), .en(en), .clr(clr),
    .pend(pend)
  );

  assign pin_low     = !pin_sync_n;
  assign pin_is_berr = (cfg.pin_lvl == '0);
  assign any_pend    = |pend;

  assign berr_out     = pin_is_berr && pin_low;
  assign pin_req_lvl  = gate_lvl(cfg.pin_lvl, pin_low);
  assign edge_req_lvl = gate_lvl(cfg.edge_lvl, any_pend);

  irq_ack_sel u_ack (
    .clk(clk), .rst_n(rst_n), .iack(iack), .iack_lvl(iack_lvl),
    .pin_req(pin_req_lvl), .edge_req(edge_req_lvl), .vec(cfg.vec),
    .ack_vec_valid(ack_vec_valid), .ack_vec(ack_vec), .ack_auto(ack_auto)
  );

  // R3: bus error only in bus-error mode
  assert_berr_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    berr_out |-> (pin_req_lvl == '0));
  // R2: pin request never differs from the programmed level
  assert_pin_lvl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_req_lvl != '0) |-> (!berr_out && bus_rdata[14:12] == pin_req_lvl || bus_addr));
  // R7: edge request needs a pending flag
  assert_edge_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_req_lvl != '0) |-> any_pend);
endmodule

// File: tb/irq_level_unit_test.sv
module irq_level_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_addr = 0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        pin_n = 1;
  logic [3:0]  edge_in = '0;
  logic        berr_out, ack_vec_valid, ack_auto, iack = 0;
  logic [2:0]  pin_req_lvl, edge_req_lvl, iack_lvl = '0;
  logic [7:0]  ack_vec;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  irq_level_unit #(.NUM_EDGE(4)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_n(pin_n),
    .edge_in(edge_in), .berr_out(berr_out), .pin_req_lvl(pin_req_lvl),
    .edge_req_lvl(edge_req_lvl), .iack(iack), .iack_lvl(iack_lvl),
    .ack_vec_valid(ack_vec_valid), .ack_vec(ack_vec), .ack_auto(ack_auto)
  );

  // write data, expected readback, expected pin level with pin low, expected berr
  localparam logic [15:0] TW [6] = '{16'h10AB, 16'hFFFF, 16'h0842, 16'h8800, 16'h3C5A, 16'h2135};
  localparam logic [15:0] TR [6] = '{16'h10AB, 16'h77FF, 16'h0042, 16'h0000, 16'h345A, 16'h2135};
  localparam logic [2:0]  TP [6] = '{3'd1, 3'd7, 3'd0, 3'd0, 3'd3, 3'd2};
  localparam logic        TB [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(logic [2:0] l);
    iack = 1; iack_lvl = l; #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    wait_n(3); rst_n = 1; wait_n(1);
    // R1 / R10 reset state
    rd(0, r); chk("R1 cfg reset", r, 16'h100F);
    chk("R10 vector reset", r[7:0], 8'h0F);
    rd(1, r); chk("R1 en/pend reset", r, 0);
    chk("R1 idle pin level", pin_req_lvl, 0);
    pin_n = 0; wait_n(3);
    chk("R1 reset pin level", pin_req_lvl, 1);
    chk("R2 no berr", berr_out, 0);

    // table walk: R4 / R10 readback, R2 / R3 pin function
    for (int i = 0; i < 6; i++) begin
      wr(0, TW[i]); wait_n(1);
      rd(0, r); chk("R4/R10 readback", r, TR[i]);
      chk("R2/R3 pin level", pin_req_lvl, TP[i]);
      chk("R3 berr", berr_out, TB[i]);
      chk("R7 no pend no req", edge_req_lvl, 0);
    end

    // R3: bus-error mode with pin released
    wr(0, 16'h0000); pin_n = 1; wait_n(3);
    chk("R3 berr pin high", berr_out, 0);
    pin_n = 0; wait_n(3);
    chk("R3 berr pin low", berr_out, 1);
    chk("R3 no req in berr mode", pin_req_lvl, 0);
    pin_n = 1; wait_n(3);

    // R5: edges with lines 0 and 2 enabled
    wr(0, 16'h2533); wr(1, 16'h0500);
    edge_in = 4'b1111; wait_n(4);
    rd(1, r); chk("R5 enabled only", r[7:0], 8'h05);
    chk("R7 edge level", edge_req_lvl, 5);
    edge_in = 4'b0000; wait_n(4);
    rd(1, r); chk("R5 fall ignored", r[7:0], 8'h05);

    // R8 / R9 acknowledge
    ack(5); chk("R8 vec valid", ack_vec_valid, 1); chk("R8 vec", ack_vec, 8'h33);
    chk("R8 no auto", ack_auto, 0);
    ack(2); chk("R9 no pin req", ack_auto, 0); chk("R8 wrong lvl", ack_vec_valid, 0);
    iack = 0;
    pin_n = 0; wait_n(3);
    ack(2); chk("R9 auto", ack_auto, 1); chk("R9 no vec", ack_vec_valid, 0);
    iack = 0;
    wr(0, 16'h5533); wait_n(1);
    ack(5); chk("R9 tie auto", ack_auto, 1); chk("R9 tie no vec", ack_vec_valid, 0);
    iack = 0;
    pin_n = 1; wait_n(3);

    // R7: edge level 0 masks request
    wr(0, 16'h5033); wait_n(1);
    chk("R7 level zero", edge_req_lvl, 0);
    wr(0, 16'h2533);

    // R6: clears
    wr(1, 16'h0501); rd(1, r); chk("R6 clear bit0", r[7:0], 8'h04);
    chk("R7 still req", edge_req_lvl, 5);
    wr(1, 16'h0500); rd(1, r); chk("R6 zero keeps", r[7:0], 8'h04);
    wr(1, 16'h0504); rd(1, r); chk("R6 clear bit2", r[7:0], 8'h00);
    chk("R7 req drops", edge_req_lvl, 0);

    // R6: collision of set and clear on line 0
    edge_in[0] = 1; wait_n(4); edge_in[0] = 0; wait_n(3);
    rd(1, r); chk("R6 pre collide", r[7:0], 8'h01);
    edge_in[0] = 1;          // driven at a negedge
    wait_n(2);               // two posedges: rise seen next cycle
    bus_wr = 1; bus_addr = 1; bus_wdata = 16'h0501;
    @(negedge clk); bus_wr = 0;
    rd(1, r); chk("R6 set wins", r[7:0], 8'h01);
    wr(1, 16'h0501); rd(1, r); chk("R6 later clear", r[7:0], 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule